// File: doc/BRIEF.md
# Serial Audio Transmit Shifter

This block turns parallel sample words into a serial bit stream. The bit clock and the frame sync come from outside. Both are sampled in the system clock domain, and the shifter acts on the detected launch edges of the bit clock. Each frame carries two words, left and then right, sent back to back with the most significant bit first. A 3-bit code selects the word length. A one-slot data delay can be switched in, which gives I2S-like framing.

Words come in through a single holding register with a ready/valid handshake. At the start of each word the shifter copies the holding register into its shift stage. If the holding register is empty at that moment, the previous word is sent again and a sticky underrun flag is raised. A frame sync that arrives in the middle of a frame is handled in one of two ways. With the ignore option set, it is dropped. Without it, the frame restarts and a sticky sync-error flag is raised. The transmit enable acts as a reset release: while it is low the whole shifter is held idle.

Top module: `serial_audio_tx`

## Requirements
- R1: `wlen_code_i` selects the word length: 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24 and 5 gives 32. Codes 6 and 7 behave as 32. Only the low word-length bits of a loaded word are sent.
- R2: Each frame sends the left word and then the right word, MSB first, with no gap between them. After the last bit of the right word, `sdata_o` stays 0 until the next frame starts.
- R3: A frame starts at a launch edge where the active frame sync is seen and was not seen at the previous launch edge. With `delay_i`=0 the MSB of the left word goes out at that edge. With `delay_i`=1 that slot carries 0 and the MSB goes out one bit clock later.
- R4: With `clk_pol_i`=1 data is launched on falling edges of `bclk_i`. With `clk_pol_i`=0 it is launched on rising edges.
- R5: With `fs_pol_i`=1 the frame sync is active low. With `fs_pol_i`=0 it is active high.
- R6: `ready_o` is high exactly when `en_i` is high and the holding register is empty. An accepted word (`valid_i` and `ready_o` at a clock edge) drops `ready_o` on the next cycle. `ready_o` rises again once the word has been copied at a word start.
- R7: If the holding register is empty at a word start, the last sent word is sent again and `underrun_o` is set. The flag stays set until `en_i` goes low.
- R8: With `fs_ignore_i`=0, a frame start seen during a frame restarts the frame at once and sets `sync_err_o`. The flag stays set until `en_i` goes low.
- R9: With `fs_ignore_i`=1, a frame start seen during a frame has no effect on the data and does not set `sync_err_o`.
- R10: While `en_i` is low (and during reset), `sdata_o`, `ready_o`, `underrun_o` and `sync_err_o` are all 0, and the holding register is emptied.
- R11: `sdata_o` changes only SYNC_STAGES+1 system clock cycles after a launch edge of `bclk_i`, or one cycle after `en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Transmit enable; low holds the shifter in reset |
| wlen_code_i | input | 3 | Word length code |
| delay_i | input | 1 | One-slot data delay after frame sync |
| clk_pol_i | input | 1 | 1: launch on falling bit-clock edge |
| fs_pol_i | input | 1 | 1: frame sync active low |
| fs_ignore_i | input | 1 | 1: drop frame syncs seen mid-frame |
| bclk_i | input | 1 | External bit clock |
| fsync_i | input | 1 | External frame sync |
| data_i | input | DATA_W | Word to load, right-justified |
| valid_i | input | 1 | Word on data_i is valid |
| ready_o | output | 1 | Holding register can accept a word |
| sdata_o | output | 1 | Serial data line |
| underrun_o | output | 1 | Sticky underrun flag |
| sync_err_o | output | 1 | Sticky unexpected frame-sync flag |

## Verification
Each bit-clock edge the bench drives passes through SYNC_STAGES synchronizer flops and one output flop. The new serial bit is therefore due exactly SYNC_STAGES+1 system cycles after the edge. The bench samples on the falling system edge one cycle before that point, expecting the previous bit, and again at that point, expecting the new bit. `ready_o` is checked on the cycle after a handshake. The sticky flags are read after the frame that should have set them, and again after the enable has been dropped.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int unsigned LEN_CODE_W = 3;

  function automatic int unsigned len_of_code(input logic [LEN_CODE_W-1:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 12;
      3'd2:    return 16;
      3'd3:    return 20;
      3'd4:    return 24;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/stx_edge_det.sv
module stx_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic fsync_i,
  input  logic clk_pol_i,
  input  logic fs_pol_i,
  output logic launch_o,
  output logic fs_act_o
);
  logic [SYNC_STAGES-1:0] b_pipe, f_pipe;
  logic b_last;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          b_pipe[0] <= 1'b0;
          f_pipe[0] <= 1'b0;
        end else begin
          b_pipe[0] <= bclk_i;
          f_pipe[0] <= fsync_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          b_pipe[g] <= 1'b0;
          f_pipe[g] <= 1'b0;
        end else begin
          b_pipe[g] <= b_pipe[g-1];
          f_pipe[g] <= f_pipe[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) b_last <= 1'b0;
    else         b_last <= b_pipe[SYNC_STAGES-1];
  end

  // launch on falling edge when clk_pol set, else on rising edge
  assign launch_o = clk_pol_i ? (b_last & ~b_pipe[SYNC_STAGES-1])
                              : (~b_last & b_pipe[SYNC_STAGES-1]);
  assign fs_act_o = f_pipe[SYNC_STAGES-1] ^ fs_pol_i;
endmodule

// File: rtl/stx_hold.sv
module stx_hold #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              take_i,
  output logic              ready_o,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (!en_i) begin
      full_q <= 1'b0;
    end else if (valid_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign ready_o = en_i & ~full_q;
  assign full_o  = full_q;
  assign data_o  = data_q;
endmodule

// File: rtl/stx_core.sv
module stx_core #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       launch_i,
  input  logic                       fs_act_i,
  input  logic [$clog2(DATA_W):0]    wlen_i,
  input  logic                       delay_i,
  input  logic                       fs_ignore_i,
  input  logic                       hold_full_i,
  input  logic [DATA_W-1:0]          hold_data_i,
  output logic                       take_o,
  output logic                       sdata_o,
  output logic                       underrun_o,
  output logic                       sync_err_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic              busy_q, in_dly_q, wsel_q, fs_prev_q, sdata_q, udr_q, serr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] word_q;

  logic              start_w, restart_w, word_end_w, begin_w;
  logic [IDX_W-1:0]  top_idx, idx_dec;
  logic [DATA_W-1:0] next_word;

  assign start_w    = launch_i & fs_act_i & ~fs_prev_q;
  assign restart_w  = start_w & (~busy_q | ~fs_ignore_i);
  assign word_end_w = busy_q & ~in_dly_q & (idx_q == '0);
  assign top_idx    = IDX_W'(wlen_i - 1'b1);
  assign idx_dec    = idx_q - 1'b1;
  assign next_word  = hold_full_i ? hold_data_i : word_q;

  always_comb begin
    begin_w = 1'b0;
    if (launch_i) begin
      if (restart_w)   begin_w = ~delay_i;
      else if (busy_q) begin_w = in_dly_q | (word_end_w & ~wsel_q);
    end
  end

  assign take_o = begin_w & hold_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      in_dly_q  <= 1'b0;
      wsel_q    <= 1'b0;
      fs_prev_q <= 1'b0;
      sdata_q   <= 1'b0;
      udr_q     <= 1'b0;
      serr_q    <= 1'b0;
      idx_q     <= '0;
      word_q    <= '0;
    end else if (!en_i) begin
      busy_q    <= 1'b0;
      in_dly_q  <= 1'b0;
      wsel_q    <= 1'b0;
      fs_prev_q <= 1'b0;
      sdata_q   <= 1'b0;
      udr_q     <= 1'b0;
      serr_q    <= 1'b0;
      idx_q     <= '0;
    end else if (launch_i) begin
      fs_prev_q <= fs_act_i;
      if (begin_w) begin
        word_q  <= next_word;
        idx_q   <= top_idx;
        sdata_q <= next_word[top_idx];
        if (!hold_full_i) udr_q <= 1'b1;
      end
      if (restart_w) begin
        busy_q   <= 1'b1;
        wsel_q   <= 1'b0;
        in_dly_q <= delay_i;
        if (busy_q)  serr_q  <= 1'b1;
        if (delay_i) sdata_q <= 1'b0;
      end else if (busy_q) begin
        if (in_dly_q) begin
          in_dly_q <= 1'b0;
        end else if (idx_q != '0) begin
          idx_q   <= idx_dec;
          sdata_q <= word_q[idx_dec];
        end else if (!wsel_q) begin
          wsel_q <= 1'b1;
        end else begin
          busy_q  <= 1'b0;
          sdata_q <= 1'b0;
        end
      end else begin
        sdata_q <= 1'b0;
      end
    end
  end

  assign sdata_o    = sdata_q;
  assign underrun_o = udr_q;
  assign sync_err_o = serr_q;
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [2:0]        wlen_code_i,
  input  logic              delay_i,
  input  logic              clk_pol_i,
  input  logic              fs_pol_i,
  input  logic              fs_ignore_i,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              sdata_o,
  output logic              underrun_o,
  output logic              sync_err_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic              launch_w, fs_act_w, take_w, hold_full_w;
  logic [DATA_W-1:0] hold_data_w;
  logic [IDX_W:0]    wlen_w;
  int unsigned       len_raw;

  always_comb begin
    len_raw = stx_pkg::len_of_code(wlen_code_i);
    if (len_raw > DATA_W) len_raw = DATA_W;
    wlen_w = (IDX_W+1)'(len_raw);
  end

  stx_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bclk_i    (bclk_i),
    .fsync_i   (fsync_i),
    .clk_pol_i (clk_pol_i),
    .fs_pol_i  (fs_pol_i),
    .launch_o  (launch_w),
    .fs_act_o  (fs_act_w)
  );

  stx_hold #(.DATA_W(DATA_W)) hold_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .data_i  (data_i),
    .valid_i (valid_i),
    .take_i  (take_w),
    .ready_o (ready_o),
    .full_o  (hold_full_w),
    .data_o  (hold_data_w)
  );

  stx_core #(.DATA_W(DATA_W)) core_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .launch_i    (launch_w),
    .fs_act_i    (fs_act_w),
    .wlen_i      (wlen_w),
    .delay_i     (delay_i),
    .fs_ignore_i (fs_ignore_i),
    .hold_full_i (hold_full_w),
    .hold_data_i (hold_data_w),
    .take_o      (take_w),
    .sdata_o     (sdata_o),
    .underrun_o  (underrun_o),
    .sync_err_o  (sync_err_o)
  );
endmodule

// File: rtl/stx_checker.sv
module stx_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic fs_ignore_i,
  input logic valid_i,
  input logic ready_o,
  input logic sdata_o,
  input logic underrun_o,
  input logic sync_err_o,
  input logic launch_i
);
  assert_disable_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sdata_o && !underrun_o && !sync_err_o));

  assert_ready_needs_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> en_i);

  assert_accept_fills_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);

  assert_underrun_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && underrun_o) ##1 en_i |-> underrun_o);

  assert_sync_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sync_err_o) ##1 en_i |-> sync_err_o);

  assert_ignore_no_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_err_o) |-> !$past(fs_ignore_i));

  assert_launch_timing_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> ($past(launch_i) || $past(!en_i)));
endmodule

bind serial_audio_tx stx_checker chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .fs_ignore_i (fs_ignore_i),
  .valid_i     (valid_i),
  .ready_o     (ready_o),
  .sdata_o     (sdata_o),
  .underrun_o  (underrun_o),
  .sync_err_o  (sync_err_o),
  .launch_i    (launch_w)
);

// File: tb/serial_audio_tx_tb_top.sv
`timescale 1ns/1ps
module serial_audio_tx_tb_top;
  localparam int SYNC = 2;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [2:0]  wlen_code_i = 3'd2;
  logic        delay_i = 1'b0, clk_pol_i = 1'b0, fs_pol_i = 1'b0, fs_ignore_i = 1'b0;
  logic        bclk_i = 1'b0, fsync_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        valid_i = 1'b0;
  logic        ready_o, sdata_o, underrun_o, sync_err_o;

  int checks = 0;
  int errors = 0;
  logic prev_exp = 1'b0;

  always #2.5 clk = ~clk;

  serial_audio_tx #(.DATA_W(32), .SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .wlen_code_i(wlen_code_i),
    .delay_i(delay_i), .clk_pol_i(clk_pol_i), .fs_pol_i(fs_pol_i),
    .fs_ignore_i(fs_ignore_i), .bclk_i(bclk_i), .fsync_i(fsync_i),
    .data_i(data_i), .valid_i(valid_i), .ready_o(ready_o), .sdata_o(sdata_o),
    .underrun_o(underrun_o), .sync_err_o(sync_err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bench_len(input logic [2:0] c);
    int t[6] = '{8, 12, 16, 20, 24, 32};
    return (c > 3'd5) ? 32 : t[c];
  endfunction

  function automatic logic exp_bit(input int s, input logic [31:0] l, input logic [31:0] r);
    int w = bench_len(wlen_code_i);
    int i = s - int'(delay_i);
    if (i < 0)     return 1'b0;
    if (i < w)     return l[w-1-i];
    if (i < 2*w)   return r[2*w-1-i];
    return 1'b0;
  endfunction

  task automatic cfg(input logic [2:0] code, input logic dly, input logic cpol,
                     input logic fpol, input logic ign);
    @(negedge clk);
    en_i = 1'b0;
    wlen_code_i = code; delay_i = dly; clk_pol_i = cpol; fs_pol_i = fpol; fs_ignore_i = ign;
    bclk_i = cpol;
    fsync_i = fpol;
    repeat (4) @(negedge clk);
    chk("R10 disabled sdata", {31'd0, sdata_o}, 32'd0);
    chk("R10 disabled ready", {31'd0, ready_o}, 32'd0);
    chk("R10 disabled flags", {30'd0, underrun_o, sync_err_o}, 32'd0);
    en_i = 1'b1;
    prev_exp = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    chk("R6 ready before load", {31'd0, ready_o}, 32'd1);
    data_i = w; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R6 ready after load", {31'd0, ready_o}, 32'd0);
  endtask

  task automatic slot(input logic fs_on, input logic expb, input string tag);
    @(negedge clk);
    bclk_i  = ~clk_pol_i;
    fsync_i = fs_on ^ fs_pol_i;
    repeat (SYNC) @(negedge clk);
    chk("R11 not yet", {31'd0, sdata_o}, {31'd0, prev_exp});
    @(negedge clk);
    chk(tag, {31'd0, sdata_o}, {31'd0, expb});
    prev_exp = expb;
    repeat (HALF - SYNC - 1) @(negedge clk);
    bclk_i = clk_pol_i;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_run(input string tag, input logic [31:0] l, input logic [31:0] r,
                           input bit have_r);
    int n = int'(delay_i) + 2*bench_len(wlen_code_i) + 2;
    for (int s = 0; s < n; s++) begin
      slot(s == 0, exp_bit(s, l, have_r ? r : l), tag);
      if (s == 1 && have_r) push(r);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] l, r;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R10 reset sdata", {31'd0, sdata_o}, 32'd0);
    chk("R10 reset ready", {31'd0, ready_o}, 32'd0);
    chk("R10 reset flags", {30'd0, underrun_o, sync_err_o}, 32'd0);
    rst_ni = 1'b1;

    // directed frames
    cfg(3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    push(32'h0000_A5C3); frame_run("R2 msb first", 32'h0000_A5C3, 32'h0000_3C5A, 1);
    @(negedge clk); chk("R6 ready after copy", {31'd0, ready_o}, 32'd1);
    cfg(3'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    push(32'h0000_8001); frame_run("R3 delay one", 32'h0000_8001, 32'h0000_7FFE, 1);
    cfg(3'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    push(32'hFFFF_FF96); frame_run("R4 falling launch", 32'hFFFF_FF96, 32'h1234_5669, 1);
    cfg(3'd3, 1'b1, 1'b1, 1'b1, 1'b0);
    push(32'h000F_0F0F); frame_run("R5 fs active low", 32'h000F_0F0F, 32'h0005_5AA5, 1);
    cfg(3'd6, 1'b0, 1'b0, 1'b0, 1'b0);
    push(32'hC000_0003); frame_run("R1 code six", 32'hC000_0003, 32'h8765_4321, 1);
    cfg(3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    push(32'hABCD_E9A5); frame_run("R1 twelve bit", 32'hABCD_E9A5, 32'h0000_0F0F, 1);
    chk("R7 no underrun", {31'd0, underrun_o}, 32'd0);

    // underrun: right word resends left
    cfg(3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    push(32'h0000_F00D); frame_run("R7 resend", 32'h0000_F00D, 32'h0, 0);
    chk("R7 underrun set", {31'd0, underrun_o}, 32'd1);
    push(32'h0000_1357); frame_run("R7 later frame", 32'h0000_1357, 32'h0000_2468, 1);
    chk("R7 underrun sticky", {31'd0, underrun_o}, 32'd1);

    // mid-frame sync restarts
    cfg(3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    l = 32'h0000_00B6;
    push(l);
    n = 5 + int'(delay_i) + 2*bench_len(wlen_code_i) + 2;
    for (int s = 0; s < n; s++)
      slot(s == 0 || s == 5, (s < 5) ? exp_bit(s, l, l) : exp_bit(s - 5, l, l), "R8 restart");
    chk("R8 sync err set", {31'd0, sync_err_o}, 32'd1);
    @(negedge clk); en_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 disable clears sync err", {31'd0, sync_err_o}, 32'd0);
    chk("R10 disable clears underrun", {31'd0, underrun_o}, 32'd0);

    // mid-frame sync ignored
    cfg(3'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    l = 32'h0000_00C9; r = 32'h0000_0072;
    push(l);
    n = int'(delay_i) + 2*bench_len(wlen_code_i) + 2;
    for (int s = 0; s < n; s++) begin
      slot(s == 0 || s == 5, exp_bit(s, l, r), "R9 ignored sync");
      if (s == 1) push(r);
    end
    chk("R9 no sync err", {31'd0, sync_err_o}, 32'd0);

    // random configurations
    for (int k = 0; k < 12; k++) begin
      cfg(3'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      l = $urandom; r = $urandom;
      push(l);
      frame_run("R1 random frame", l, r, 1);
      chk("R7 random no underrun", {31'd0, underrun_o}, 32'd0);
      chk("R8 random no sync err", {31'd0, sync_err_o}, 32'd0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule